// File: doc/BRIEF.md
# Static Memory Strobe Timing Controller

This block sits between a simple host request port and an external asynchronous static memory, such as SRAM or NOR flash. A request names a chip select, an address, a direction and, for writes, a data word. The block holds the address for the whole access. It then produces active-low strobes whose assertion points and widths are counted in clock cycles. When the programmed access length has run out, it reports completion to the host, together with the read data for reads.

Four chip selects are served. Each one has its own timing set: a setup field and a pulse field for each of four strobes (dedicated write strobe, chip-select-during-write, dedicated read strobe, chip-select-during-read), one total-length field per direction, and two mode bits. The mode bits pick whether the dedicated strobe or the chip select governs the data phase. The fields use a compressed encoding in which the top bits add large offsets. No hold time is programmed. Whatever the total length leaves after the governing setup and pulse is the hold.

The timing fields arrive as parallel configuration inputs. A configuration that cannot work raises a sticky error flag, and the access completes without touching the memory pins.

Top module: `asyncMemTimer`

## Requirements
- R1: After reset, memWeN, memRdN and every memCsN line are high, memDoe is low, reqReady is high, and accDone and cfgErr are low.
- R2: A setup field is 6 bits with effective value 128*bit5 + bits4:0. Cycle t=0 is the first clock after acceptance. A strobe is low in exactly the cycles t with setup <= t < setup+pulse, so a setup of 0 asserts it at t=0.
- R3: A pulse field is 7 bits with effective value 256*bit6 + bits5:0.
- R4: A total-length field is 9 bits with effective value 256*bits8:7 + bits6:0.
  - reqReady is low for exactly that many cycles after a valid request is accepted.
  - accDone is high for one cycle in the cycle that follows.
- R5: Setup and pulse fields for chip select c and strobe s sit at field index c*4+s. The strobe order is s=0 write strobe, 1 chip-select-on-write, 2 read strobe, 3 chip-select-on-read. The total-length field for direction d (0 write, 1 read) sits at index c*2+d.
  - A write uses only strobes 0 and 1, and a read uses only 2 and 3.
  - Only the addressed memCsN line can go low.
- R6: During a write, memDoe rises when the governing strobe's setup ends and stays high to the end of the access. cfgWrByCs[c]=0 makes the write strobe govern, and 1 makes the chip select govern. memDout equals the request's write data while memDoe is high.
- R7: A read samples memDin in the last pulse cycle of the governing strobe and returns it on rdData while accDone is high. cfgRdByCs[c]=0 makes the read strobe govern, and 1 makes the chip select govern.
- R8: A request is invalid if either of its two pulses is zero, or if its total length is below setup+pulse of either strobe.
  - An invalid request sets cfgErr, which stays set until reset.
  - It drives no strobe and raises accDone in the cycle after acceptance.
- R9: memAddr and memDout hold the accepted values for the whole access whatever the request inputs do. A request is not accepted while reqReady is low.
- R10: memDoe is low during reads and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle; request taken when both are high |
| reqWrite | input | 1 | 1 write, 0 read |
| reqCs | input | 2 | Chip select index |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 16 | Write data |
| accDone | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read data, valid with accDone after a read |
| cfgSetup | input | 96 | Setup fields, 6 bits each, index cs*4+strobe |
| cfgPulse | input | 112 | Pulse fields, 7 bits each, index cs*4+strobe |
| cfgCycle | input | 72 | Total-length fields, 9 bits each, index cs*2+dir |
| cfgWrByCs | input | 4 | Per chip select: chip select governs writes |
| cfgRdByCs | input | 4 | Per chip select: chip select governs reads |
| cfgErr | output | 1 | Sticky invalid-configuration flag |
| memAddr | output | 16 | Memory address |
| memDout | output | 16 | Data toward memory |
| memDoe | output | 1 | Data bus output enable |
| memDin | input | 16 | Data from memory |
| memCsN | output | 4 | Chip selects, active low |
| memWeN | output | 1 | Write strobe, active low |
| memRdN | output | 1 | Read strobe, active low |

## Verification
The bench checks the edges of every strobe cycle by cycle, including a setup of 0 and field values that use the high offset bits. An offset weighted wrongly or a pulse window off by one shows up as a strobe that moves or changes width. It runs a read whose hold is zero, so the sample falls in the very last cycle; a completion pulse raised too early would return stale data there. Both settings of each mode bit are exercised, and a wrong enable point shows up as memDoe rising at the wrong strobe's setup. Invalid configurations must leave every strobe quiet while cfgErr stays set. A request held high during a busy access must not be taken early, and the address must not follow the changing host inputs.

// File: rtl/asyncMemPkg.sv
package asyncMemPkg;

  // encoded field widths and decoded counter width
  localparam int SU_W  = 6;
  localparam int PU_W  = 7;
  localparam int CY_W  = 9;
  localparam int CNT_W = 10;
  localparam int SIGS  = 4;

  // strobe order inside one chip-select group
  localparam int SIG_WR_STB = 0;
  localparam int SIG_WR_CS  = 1;
  localparam int SIG_RD_STB = 2;
  localparam int SIG_RD_CS  = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // capture host address and data
    logic busy;     // access in progress
    logic drive;    // data bus enabled toward memory
    logic capture;  // sample memory read data
  } memStrobes_t;

  function automatic logic [CNT_W-1:0] decSetup(input logic [SU_W-1:0] raw);
    return CNT_W'({raw[5], 7'd0}) + CNT_W'(raw[4:0]);
  endfunction

  function automatic logic [CNT_W-1:0] decPulse(input logic [PU_W-1:0] raw);
    return CNT_W'({raw[6], 8'd0}) + CNT_W'(raw[5:0]);
  endfunction

  function automatic logic [CNT_W-1:0] decCycle(input logic [CY_W-1:0] raw);
    return CNT_W'({raw[8:7], 8'd0}) + CNT_W'(raw[6:0]);
  endfunction

  function automatic logic inWindow(input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] su,
                                    input logic [CNT_W-1:0] pu);
    return (cnt >= su) && (cnt < su + pu);
  endfunction

endpackage

// File: rtl/asyncMemCtrl.sv
module asyncMemCtrl
  import asyncMemPkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [CS_W-1:0]            reqCs,
  output logic                       reqReady,
  output logic                       accDone,
  input  logic [NUM_CS*SIGS*SU_W-1:0] cfgSetup,
  input  logic [NUM_CS*SIGS*PU_W-1:0] cfgPulse,
  input  logic [NUM_CS*2*CY_W-1:0]   cfgCycle,
  input  logic [NUM_CS-1:0]          cfgWrByCs,
  input  logic [NUM_CS-1:0]          cfgRdByCs,
  output logic                       cfgErr,
  output logic [NUM_CS-1:0]          memCsN,
  output logic                       memWeN,
  output logic                       memRdN,
  output memStrobes_t                stb
);

  // decode of the timing set addressed by the pending request
  logic [CNT_W-1:0] nSuD, nPuD, nSuC, nPuC, nCyc;
  logic             nByCs, nBad;
  int               baseD, baseC, baseY;

  always_comb begin
    baseD = int'(reqCs) * SIGS + (reqWrite ? SIG_WR_STB : SIG_RD_STB);
    baseC = int'(reqCs) * SIGS + (reqWrite ? SIG_WR_CS  : SIG_RD_CS);
    baseY = int'(reqCs) * 2 + (reqWrite ? 0 : 1);
    nSuD  = decSetup(cfgSetup[baseD*SU_W +: SU_W]);
    nPuD  = decPulse(cfgPulse[baseD*PU_W +: PU_W]);
    nSuC  = decSetup(cfgSetup[baseC*SU_W +: SU_W]);
    nPuC  = decPulse(cfgPulse[baseC*PU_W +: PU_W]);
    nCyc  = decCycle(cfgCycle[baseY*CY_W +: CY_W]);
    nByCs = reqWrite ? cfgWrByCs[reqCs] : cfgRdByCs[reqCs];
    nBad  = (nPuD == '0) || (nPuC == '0) ||
            (nCyc < nSuD + nPuD) || (nCyc < nSuC + nPuC);
  end

  // latched access state
  logic             busy, isWr, doneQ, errQ, ctlByCs, accept;
  logic [CS_W-1:0]  csSel;
  logic [CNT_W-1:0] cnt, suD, puD, suC, puC, cycLen;

  assign accept = reqValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isWr    <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
      ctlByCs <= 1'b0;
      csSel   <= '0;
      cnt     <= '0;
      suD     <= '0;
      puD     <= '0;
      suC     <= '0;
      puC     <= '0;
      cycLen  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        isWr    <= reqWrite;
        csSel   <= reqCs;
        ctlByCs <= nByCs;
        suD     <= nSuD;
        puD     <= nPuD;
        suC     <= nSuC;
        puC     <= nPuC;
        cycLen  <= nCyc;
        cnt     <= '0;
        if (nBad) begin
          errQ  <= 1'b1;
          doneQ <= 1'b1;
        end else begin
          busy  <= 1'b1;
        end
      end else if (busy) begin
        if (cnt == cycLen - CNT_W'(1)) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // strobe windows from the single cycle counter
  logic [CNT_W-1:0] ctlSu, ctlPu;
  logic             dedOn, csOn;

  assign ctlSu = ctlByCs ? suC : suD;
  assign ctlPu = ctlByCs ? puC : puD;
  assign dedOn = busy && inWindow(cnt, suD, puD);
  assign csOn  = busy && inWindow(cnt, suC, puC);

  assign memWeN = !(dedOn && isWr);
  assign memRdN = !(dedOn && !isWr);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign memCsN[i] = !(csOn && (csSel == CS_W'(i)));
  end

  assign stb.load    = accept;
  assign stb.busy    = busy;
  assign stb.drive   = busy && isWr && (cnt >= ctlSu);
  assign stb.capture = busy && !isWr && (cnt == ctlSu + ctlPu - CNT_W'(1));

  assign reqReady = !busy;
  assign accDone  = doneQ;
  assign cfgErr   = errQ;

  // R4
  cycle_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt == cycLen - CNT_W'(1)) |=> (doneQ && !busy));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt < cycLen));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  // R8
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> (doneQ && memWeN && memRdN && (&memCsN)));

  // R5
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R10
  drive_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.drive |-> memRdN);

endmodule

// File: rtl/asyncMemDatapath.sv
module asyncMemDatapath
  import asyncMemPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ, rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      rdQ   <= '0;
    end else begin
      if (stb.load) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
      end
      if (stb.capture) rdQ <= memDin;
    end
  end

  assign memAddr = addrQ;
  assign memDout = wdQ;
  assign memDoe  = stb.drive;
  assign rdData  = rdQ;

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && $past(stb.busy)) |-> $stable(memAddr));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.drive && $past(stb.drive)) |-> $stable(memDout));

  // R7
  capture_not_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> !stb.drive);

endmodule

// File: rtl/asyncMemTimer.sv
module asyncMemTimer
  import asyncMemPkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic                        reqWrite,
  input  logic [CS_W-1:0]             reqCs,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic                        accDone,
  output logic [DATA_W-1:0]           rdData,
  input  logic [NUM_CS*SIGS*SU_W-1:0] cfgSetup,
  input  logic [NUM_CS*SIGS*PU_W-1:0] cfgPulse,
  input  logic [NUM_CS*2*CY_W-1:0]    cfgCycle,
  input  logic [NUM_CS-1:0]           cfgWrByCs,
  input  logic [NUM_CS-1:0]           cfgRdByCs,
  output logic                        cfgErr,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [DATA_W-1:0]           memDout,
  output logic                        memDoe,
  input  logic [DATA_W-1:0]           memDin,
  output logic [NUM_CS-1:0]           memCsN,
  output logic                        memWeN,
  output logic                        memRdN
);

  memStrobes_t stb;

  asyncMemCtrl #(.NUM_CS(NUM_CS), .CS_W(CS_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .reqReady(reqReady), .accDone(accDone),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgCycle(cfgCycle),
    .cfgWrByCs(cfgWrByCs), .cfgRdByCs(cfgRdByCs), .cfgErr(cfgErr),
    .memCsN(memCsN), .memWeN(memWeN), .memRdN(memRdN),
    .stb(stb)
  );

  asyncMemDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .memDin(memDin),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe), .rdData(rdData)
  );

endmodule

// File: tb/asyncMemTimer_tb_top.sv
`timescale 1ns/1ps
module asyncMemTimer_tb_top;

  localparam int NCS = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqCs = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [NCS*4*6-1:0] cfgSetup = '0;
  logic [NCS*4*7-1:0] cfgPulse = '0;
  logic [NCS*2*9-1:0] cfgCycle = '0;
  logic [NCS-1:0] cfgWrByCs = '0, cfgRdByCs = '0;
  logic [DW-1:0] memDin;
  logic [15:0] tbCyc = '0;

  logic reqReady, accDone, cfgErr, memDoe, memWeN, memRdN;
  logic [DW-1:0] rdData, memDout;
  logic [AW-1:0] memAddr;
  logic [NCS-1:0] memCsN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;
  always @(posedge clk) tbCyc <= tbCyc + 16'd1;
  assign memDin = tbCyc ^ 16'h5a3c;

  asyncMemTimer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .accDone(accDone), .rdData(rdData),
    .cfgSetup(cfgSetup), .cfgPulse(cfgPulse), .cfgCycle(cfgCycle),
    .cfgWrByCs(cfgWrByCs), .cfgRdByCs(cfgRdByCs), .cfgErr(cfgErr),
    .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe), .memDin(memDin),
    .memCsN(memCsN), .memWeN(memWeN), .memRdN(memRdN)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int effSu(input logic [5:0] r);
    return int'(r[5]) * 128 + int'(r[4:0]);
  endfunction
  function automatic int effPu(input logic [6:0] r);
    return int'(r[6]) * 256 + int'(r[5:0]);
  endfunction
  function automatic int effCy(input logic [8:0] r);
    return int'(r[8:7]) * 256 + int'(r[6:0]);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic setCfg(input bit wr, input int cs, input logic [5:0] rSuD, input logic [6:0] rPuD,
                        input logic [5:0] rSuC, input logic [6:0] rPuC, input logic [8:0] rCyc,
                        input bit byCs);
    int d;
    d = cs * 4 + (wr ? 0 : 2);
    cfgSetup[d*6 +: 6]     = rSuD;
    cfgSetup[(d+1)*6 +: 6] = rSuC;
    cfgPulse[d*7 +: 7]     = rPuD;
    cfgPulse[(d+1)*7 +: 7] = rPuC;
    cfgCycle[(cs*2 + (wr ? 0 : 1))*9 +: 9] = rCyc;
    if (wr) cfgWrByCs[cs] = byCs;
    else    cfgRdByCs[cs] = byCs;
  endtask

  task automatic checkIdle(input string tag);
    chk("R1", {tag, " memWeN"}, memWeN, 1);
    chk("R1", {tag, " memRdN"}, memRdN, 1);
    chk("R1", {tag, " memCsN"}, memCsN, 4'hf);
    chk("R10", {tag, " memDoe idle"}, memDoe, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkIdle("reset");
    chk("R1", "reqReady", reqReady, 1);
    chk("R1", "accDone", accDone, 0);
    chk("R1", "cfgErr", cfgErr, 0);
  endtask

  // one valid access, checked every cycle
  task automatic runAccess(input string tag, input bit wr, input int cs,
                           input logic [5:0] rSuD, input logic [6:0] rPuD,
                           input logic [5:0] rSuC, input logic [6:0] rPuC,
                           input logic [8:0] rCyc, input bit byCs,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wdata);
    int suD, puD, suC, puC, cyc, ctlSu, ctlEnd;
    bit dedOn, csOn, doeExp;
    logic [DW-1:0] sampled;
    sampled = '0;
    setCfg(wr, cs, rSuD, rPuD, rSuC, rPuC, rCyc, byCs);
    suD = effSu(rSuD); puD = effPu(rPuD);
    suC = effSu(rSuC); puC = effPu(rPuC);
    cyc = effCy(rCyc);
    ctlSu  = byCs ? suC : suD;
    ctlEnd = byCs ? suC + puC : suD + puD;
    @(negedge clk);
    chk("R4", {tag, " ready before request"}, reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqCs = 2'(cs);
    reqAddr = addr; reqWdata = wdata;
    @(posedge clk);
    for (int t = 0; t < cyc; t++) begin
      @(negedge clk);
      if (t == 0) begin
        reqValid = 1'b0; reqAddr = ~addr; reqWdata = ~wdata;
      end
      dedOn  = (t >= suD) && (t < suD + puD);
      csOn   = (t >= suC) && (t < suC + puC);
      doeExp = wr && (t >= ctlSu);
      chk("R2", {tag, " memWeN window"}, memWeN, !(wr && dedOn));
      chk("R2", {tag, " memRdN window"}, memRdN, !(!wr && dedOn));
      for (int i = 0; i < NCS; i++)
        chk("R5", {tag, " memCsN line"}, memCsN[i], !(i == cs && csOn));
      chk(wr ? "R6" : "R10", {tag, " memDoe"}, memDoe, doeExp);
      if (doeExp) chk("R6", {tag, " memDout"}, memDout, wdata);
      chk("R9", {tag, " memAddr held"}, memAddr, addr);
      chk("R4", {tag, " reqReady busy"}, reqReady, 0);
      chk("R4", {tag, " accDone early"}, accDone, 0);
      if (t == ctlEnd - 1) sampled = memDin;
    end
    @(negedge clk);
    chk("R4", {tag, " accDone at end"}, accDone, 1);
    chk("R4", {tag, " reqReady at end"}, reqReady, 1);
    chk("R10", {tag, " memDoe after"}, memDoe, 0);
    if (!wr) chk("R7", {tag, " rdData"}, rdData, sampled);
  endtask

  // invalid configuration: quiet completion plus sticky flag
  task automatic runBad(input string tag, input bit wr, input int cs,
                        input logic [5:0] rSuD, input logic [6:0] rPuD,
                        input logic [5:0] rSuC, input logic [6:0] rPuC,
                        input logic [8:0] rCyc);
    setCfg(wr, cs, rSuD, rPuD, rSuC, rPuC, rCyc, 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqCs = 2'(cs); reqAddr = 16'h0bad;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", {tag, " accDone next cycle"}, accDone, 1);
    chk("R8", {tag, " cfgErr set"}, cfgErr, 1);
    chk("R8", {tag, " memWeN quiet"}, memWeN, 1);
    chk("R8", {tag, " memRdN quiet"}, memRdN, 1);
    chk("R8", {tag, " memCsN quiet"}, memCsN, 4'hf);
    chk("R8", {tag, " memDoe quiet"}, memDoe, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", {tag, " strobes stay quiet"}, {memWeN, memRdN, memCsN}, 6'h3f);
      chk("R8", {tag, " single done"}, accDone, 0);
      chk("R8", {tag, " cfgErr sticky"}, cfgErr, 1);
    end
  endtask

  // request held high through a busy access
  task automatic testBusyIgnore();
    int waitCnt;
    bit seen;
    setCfg(1'b1, 0, 6'd0, 7'd2, 6'd0, 7'd2, 9'd4, 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqCs = 2'd0;
    reqAddr = 16'h1111; reqWdata = 16'haaaa;
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      reqAddr = 16'h2222; reqWdata = 16'h5555;
      chk("R9", "busy: address not replaced", memAddr, 16'h1111);
      chk("R9", "busy: not ready", reqReady, 0);
    end
    @(negedge clk);
    chk("R9", "first done", accDone, 1);
    chk("R9", "ready after first", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9", "second taken back to back", memAddr, 16'h2222);
    chk("R9", "second busy", reqReady, 0);
    seen = 1'b0;
    waitCnt = 0;
    while (!seen && waitCnt < 20) begin
      @(negedge clk);
      if (accDone) seen = 1'b1;
      waitCnt++;
    end
    chk("R4", "second access completes", seen, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    testReset();
    // write, write strobe governs, chip select setup 0
    runAccess("wr cs0 ded", 1'b1, 0, 6'd1, 7'd3, 6'd0, 7'd5, 9'd7, 1'b0, 16'h1234, 16'hbeef);
    // write, chip select governs
    runAccess("wr cs2 bycs", 1'b1, 2, 6'd2, 7'd2, 6'd1, 7'd4, 9'd6, 1'b1, 16'h4321, 16'hc0de);
    // read, read strobe governs
    runAccess("rd cs1 ded", 1'b0, 1, 6'd2, 7'd2, 6'd1, 7'd4, 9'd6, 1'b0, 16'h0042, 16'h0000);
    // read, chip select governs, zero hold
    runAccess("rd cs3 bycs hold0", 1'b0, 3, 6'd0, 7'd3, 6'd2, 7'd3, 9'd5, 1'b1, 16'h7777, 16'h0000);
    // R3: offset bits of setup, pulse and total length
    runAccess("R3 wide fields", 1'b1, 1, 6'b100010, 7'b1000001, 6'd0, 7'd1, 9'b100000000,
              1'b0, 16'h0abc, 16'h1357);
    testBusyIgnore();
    runBad("zero pulse", 1'b0, 2, 6'd1, 7'd0, 6'd0, 7'd3, 9'd5);
    doReset();
    testReset();
    runBad("short cycle", 1'b1, 0, 6'd2, 7'd3, 6'd0, 7'd2, 9'd4);
    runAccess("after error", 1'b0, 0, 6'd1, 7'd2, 6'd0, 7'd4, 9'd5, 1'b0, 16'h0101, 16'h0000);
    chk("R8", "cfgErr still set after valid access", cfgErr, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule